// File: doc/BRIEF.md
# Bridge configuration header register file

This block holds the configuration registers of a bridge-type function: the 64-byte type-1 header and, when the `HAS_CAP` parameter is set, a PCIe capability structure that starts at byte 0x40 and ends after the second slot status register (byte 0x7B). A single request port carries reads and writes of 1, 2 or 4 bytes at any byte address. Every request gets a registered response one clock later, with read data and an error flag.

Each bit of every 32-bit word has one fixed attribute: read-write, read-only, write-1-to-clear, or reserved (always reads zero). A narrow write is a read-modify-write of the whole word. It is limited to the byte lanes the access covers, and only read-write and write-1-to-clear bits respond to it. Logic outside the block raises status bits through a separate event port. That port can only set write-1-to-clear bits.

Identity values (vendor, device, class, revision) are parameters. Reset loads them together with the fixed header and capability values.

Top module: `cfgspace_regfile`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise.
- R2: For a read, the word is selected by the address with its two low bits cleared. A 1-byte or 2-byte read returns the word shifted right by 8×addr[1:0] and masked to 8 or 16 bits. A 4-byte access ignores addr[1:0].
- R3: A size other than 1, 2 or 4 sets `rsp_err`, returns zero data and changes no register.
- R4: Addresses at or above 0x40 (no capability) or 0x7C (with capability) read as zero and ignore writes.
- R5: Reserved bits always read as zero. For example, word 0x38 reads 0xFFFFF801 after an all-ones write.
- R6: A write changes only read-write bits inside the byte lanes of the access. The write data is shifted left by 8×addr[1:0]. All other bits keep their value.
- R7: A write-1-to-clear bit inside the lanes is cleared by a 1 in the shifted data. A 0 leaves it unchanged.
- R8: After reset, the registers hold these values:
  - word 0x00 = {DEV_ID, VEN_ID}
  - word 0x04 = 0x00100000
  - word 0x08 = {CLASS_CODE, REV_ID}
  - word 0x0C = 0x00010010
  - word 0x34 = 0x40 with the capability, 0 without it
  - word 0x40 = 0x01420010
- R9: In word 0x04, bits 0, 1, 2, 6 and 8 are read-write, and bits 24 and 27–31 are write-1-to-clear.
- R10: In words 0x20 and 0x24, bits 31:20 and 15:4 are read-write and the rest read-only. In word 0x1C, bits 15:12 and 7:4 are read-write and bits 24 and 27–31 are write-1-to-clear.
- R11: In word 0x48, bits 15:0 are read-write, bits 19:16 are write-1-to-clear and bits 31:21 are reserved. In word 0x50, bits 11:3 and 1:0 are read-write, bits 31:30 are write-1-to-clear, and bits 15:12 and bit 2 are reserved.
- R12: When `evt_valid` is high, the write-1-to-clear bits of word `evt_word` (a word index, that is, byte address/4) that are set in `evt_bits` become 1. Other bits of `evt_bits` have no effect. If an event set and a write-1-to-clear clear hit the same bit in the same cycle, the set wins.
- R13: A write takes effect at the edge that ends its request cycle, so a read in the next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| evt_valid | input | 1 | Status event present |
| evt_word | input | EVT_W | Word index the event targets |
| evt_bits | input | 32 | Bits to set (only write-1-to-clear bits take effect) |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, right-aligned, zero for writes |
| rsp_err | output | 1 | Illegal access size |

## Verification
The hardest case to reach is a bit that is set by an event and cleared by a write-1-to-clear write in the same cycle. It needs both ports aimed at the same word and lane on one edge, so the bench builds it directly.

Narrow writes straddling the top byte (size 2 at offset 3) are also rare from ordinary software patterns. A long mixed sequence of random sizes, offsets, events and out-of-window addresses reaches them, and every cycle is compared against a behavioural model of the word attributes. A second instance built without the capability confirms that its window stops at 0x40.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

  localparam int HDR_WORDS = 16;
  localparam int CAP_WORDS = 15;

  typedef struct packed {
    logic [31:0] rw;
    logic [31:0] w1c;
    logic [31:0] rsvd;
  } attr_t;

  // Per-word attribute masks; any bit in none of the masks is read-only.
  function automatic attr_t attr_of(input int idx);
    attr_t a;
    a = '{rw: 32'h0, w1c: 32'h0, rsvd: 32'h0};
    case (idx)
      1:  a = '{rw: 32'h0000_0147, w1c: 32'hF900_0000, rsvd: 32'h004F_FC00};
      6:  a = '{rw: 32'h00FF_FFFF, w1c: 32'h0, rsvd: 32'h0};
      7:  a = '{rw: 32'h0000_F0F0, w1c: 32'hF900_0000, rsvd: 32'h005F_0000};
      8,
      9:  a = '{rw: 32'hFFF0_FFF0, w1c: 32'h0, rsvd: 32'h0};
      10,
      11,
      12: a = '{rw: 32'hFFFF_FFFF, w1c: 32'h0, rsvd: 32'h0};
      13: a = '{rw: 32'h0, w1c: 32'h0, rsvd: 32'hFFFF_FF00};
      14: a = '{rw: 32'hFFFF_F801, w1c: 32'h0, rsvd: 32'h0000_07FE};
      15: a = '{rw: 32'h0B6F_00FF, w1c: 32'h0400_0000, rsvd: 32'hF010_0000};
      18: a = '{rw: 32'h0000_FFFF, w1c: 32'h000F_0000, rsvd: 32'hFFE0_0000};
      19: a = '{rw: 32'h0, w1c: 32'h0, rsvd: 32'h0080_0000};
      20: a = '{rw: 32'h0000_0FFB, w1c: 32'hC000_0000, rsvd: 32'h0000_F004};
      22: a = '{rw: 32'h0000_1FFF, w1c: 32'h011F_0000, rsvd: 32'hFE00_F000};
      23: a = '{rw: 32'h0000_001F, w1c: 32'h0, rsvd: 32'hFFFE_FFE0};
      24: a = '{rw: 32'h0, w1c: 32'h0001_0000, rsvd: 32'hFFFC_0000};
      default: a = '{rw: 32'h0, w1c: 32'h0, rsvd: 32'h0};
    endcase
    return a;
  endfunction

endpackage

// File: rtl/cfgsp_lane.sv
module cfgsp_lane (
  input  logic [2:0]  size,
  input  logic [1:0]  offs,
  output logic        legal,
  output logic [4:0]  shamt,
  output logic [31:0] lane,
  output logic [31:0] rmask
);
  always_comb begin
    legal = 1'b0;
    shamt = 5'd0;
    lane  = 32'h0;
    rmask = 32'h0;
    case (size)
      3'd1: begin
        legal = 1'b1;
        shamt = {offs, 3'b000};
        lane  = 32'h0000_00FF << shamt;
        rmask = 32'h0000_00FF;
      end
      3'd2: begin
        legal = 1'b1;
        shamt = {offs, 3'b000};
        lane  = 32'h0000_FFFF << shamt;
        rmask = 32'h0000_FFFF;
      end
      3'd4: begin
        legal = 1'b1;
        shamt = 5'd0;
        lane  = 32'hFFFF_FFFF;
        rmask = 32'hFFFF_FFFF;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cfgsp_word.sv
module cfgsp_word #(
  parameter logic [31:0] RW_M  = 32'h0,
  parameter logic [31:0] W1C_M = 32'h0,
  parameter logic [31:0] RST_V = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] lane,
  input  logic [31:0] sdata,
  input  logic        evt_en,
  input  logic [31:0] evt_bits,
  output logic [31:0] q
);
  logic [31:0] upd;
  logic [31:0] nxt;

  always_comb begin
    upd = (q & ~(RW_M & lane)) | (sdata & RW_M & lane);
    upd = upd & ~(sdata & W1C_M & lane);
    nxt = wr_en ? upd : q;
    if (evt_en) nxt = nxt | (evt_bits & W1C_M);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RST_V;
    else     q <= nxt;
  end
endmodule

// File: rtl/cfgspace_regfile.sv
module cfgspace_regfile #(
  parameter int          ADDR_W     = 12,
  parameter int          EVT_W      = 5,
  parameter bit          HAS_CAP    = 1'b1,
  parameter logic [15:0] VEN_ID     = 16'hA5C3,
  parameter logic [15:0] DEV_ID     = 16'h0B1E,
  parameter logic [23:0] CLASS_CODE = 24'h060400,
  parameter logic [7:0]  REV_ID     = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic              evt_valid,
  input  logic [EVT_W-1:0]  evt_word,
  input  logic [31:0]       evt_bits,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err
);
  import cfgsp_pkg::*;

  localparam int NWORDS = HAS_CAP ? (HDR_WORDS + CAP_WORDS) : HDR_WORDS;
  localparam int WIDX_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] END_ADDR = ADDR_W'(NWORDS * 4);

  function automatic logic [31:0] rst_of(input int i);
    case (i)
      0:  return {DEV_ID, VEN_ID};
      1:  return 32'h0010_0000;
      2:  return {CLASS_CODE, REV_ID};
      3:  return 32'h0001_0010;
      13: return HAS_CAP ? 32'h0000_0040 : 32'h0;
      16: return 32'h0142_0010;
      default: return 32'h0;
    endcase
  endfunction

  logic        legal;
  logic [4:0]  shamt;
  logic [31:0] lane, rmask, sdata, rd_raw;
  logic [WIDX_W-1:0] widx;
  logic        in_win, do_wr;
  logic [31:0] vis [NWORDS];

  cfgsp_lane u_lane (
    .size (req_size),
    .offs (req_addr[1:0]),
    .legal(legal),
    .shamt(shamt),
    .lane (lane),
    .rmask(rmask)
  );

  assign widx   = req_addr[ADDR_W-1:2];
  assign in_win = req_addr < END_ADDR;
  assign do_wr  = req_valid && req_write && legal && in_win;
  assign sdata  = req_wdata << shamt;

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    localparam attr_t A = attr_of(g);
    logic [31:0] q;
    cfgsp_word #(
      .RW_M (A.rw),
      .W1C_M(A.w1c),
      .RST_V(rst_of(g) & ~A.rsvd)
    ) u_word (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (do_wr && (widx == WIDX_W'(g))),
      .lane    (lane),
      .sdata   (sdata),
      .evt_en  (evt_valid && (evt_word == EVT_W'(g))),
      .evt_bits(evt_bits),
      .q       (q)
    );
    assign vis[g] = q & ~A.rsvd;
  end

  always_comb begin
    rd_raw = 32'h0;
    for (int i = 0; i < NWORDS; i++)
      if (widx == WIDX_W'(i)) rd_raw = vis[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= 32'h0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !legal;
      rsp_rdata <= (req_valid && !req_write && legal && in_win)
                   ? ((rd_raw >> shamt) & rmask) : 32'h0;
    end
  end
endmodule

// File: rtl/cfgsp_chk.sv
module cfgsp_chk #(
  parameter int ADDR_W  = 12,
  parameter bit HAS_CAP = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [2:0]        req_size,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err
);
  localparam logic [ADDR_W-1:0] LIM = HAS_CAP ? ADDR_W'(124) : ADDR_W'(64);

  logic ok_size;
  assign ok_size = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);

  // R1
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R1
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R3
  bad_size_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ok_size) |=> (rsp_err && rsp_rdata == 32'h0));
  // R3
  good_size_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ok_size) |=> !rsp_err);
  // R4
  window_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_addr >= LIM) |=> (rsp_rdata == 32'h0));
  // R2
  byte_width_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_size == 3'd1) |=> (rsp_rdata[31:8] == 24'h0));
  // R2
  half_width_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_size == 3'd2) |=> (rsp_rdata[31:16] == 16'h0));
  // R6
  write_nodata_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> (rsp_rdata == 32'h0));
endmodule

bind cfgspace_regfile cfgsp_chk #(.ADDR_W(ADDR_W), .HAS_CAP(HAS_CAP)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_size (req_size),
  .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata),
  .rsp_err  (rsp_err)
);

// File: tb/sim_cfgspace_regfile.sv
module sim_cfgspace_regfile;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, req_valid, req_write, evt_valid;
  logic [11:0] req_addr;
  logic [2:0]  req_size;
  logic [31:0] req_wdata, evt_bits;
  logic [4:0]  evt_word;
  logic        rsp_valid, rsp_err, r1_valid, r1_err;
  logic [31:0] rsp_rdata, r1_rdata;

  cfgspace_regfile u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .evt_valid(evt_valid), .evt_word(evt_word), .evt_bits(evt_bits),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));

  cfgspace_regfile #(.HAS_CAP(1'b0)) u1 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .evt_valid(evt_valid), .evt_word(evt_word), .evt_bits(evt_bits),
    .rsp_valid(r1_valid), .rsp_rdata(r1_rdata), .rsp_err(r1_err));

  int checks = 0;
  int fails  = 0;
  logic [31:0] m [0:30];

  function automatic logic [31:0] m_rw(input int i);
    case (i)
      1: return 32'h147;        6: return 32'h00FFFFFF;  7: return 32'hF0F0;
      8, 9: return 32'hFFF0FFF0; 10, 11, 12: return 32'hFFFFFFFF;
      14: return 32'hFFFFF801;  15: return 32'h0B6F00FF; 18: return 32'hFFFF;
      20: return 32'h0FFB;      22: return 32'h1FFF;     23: return 32'h1F;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] m_w1c(input int i);
    case (i)
      1, 7: return 32'hF9000000; 15: return 32'h04000000; 18: return 32'h000F0000;
      20: return 32'hC0000000;   22: return 32'h011F0000; 24: return 32'h00010000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] m_rs(input int i);
    case (i)
      1: return 32'h004FFC00;  7: return 32'h005F0000;  13: return 32'hFFFFFF00;
      14: return 32'h000007FE; 15: return 32'hF0100000; 18: return 32'hFFE00000;
      19: return 32'h00800000; 20: return 32'h0000F004; 22: return 32'hFE00F000;
      23: return 32'hFFFEFFE0; 24: return 32'hFFFC0000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [33:0] got, input logic [33:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One clock: drive request and event, advance the model, compare the response.
  task automatic step(input logic v, input logic wr, input logic [11:0] a,
                      input logic [2:0] s, input logic [31:0] d, input logic ev,
                      input logic [4:0] ew, input logic [31:0] eb, input string tag);
    logic lg, inw;
    int sh, wi;
    logic [31:0] ln, rm, sd, nw, ed;
    lg  = (s == 3'd1) || (s == 3'd2) || (s == 3'd4);
    sh  = (s == 3'd4) ? 0 : 8 * int'(a[1:0]);
    ln  = (s == 3'd1) ? (32'hFF << sh) : (s == 3'd2) ? (32'hFFFF << sh) : 32'hFFFFFFFF;
    rm  = (s == 3'd1) ? 32'hFF : (s == 3'd2) ? 32'hFFFF : 32'hFFFFFFFF;
    wi  = int'(a) / 4;
    inw = int'(a) < 124;
    ed  = 32'h0;
    if (v && !wr && lg && inw) ed = ((m[wi] & ~m_rs(wi)) >> sh) & rm;
    if (v && wr && lg && inw) begin
      sd = d << sh;
      nw = (m[wi] & ~(m_rw(wi) & ln)) | (sd & m_rw(wi) & ln);
      m[wi] = nw & ~(sd & m_w1c(wi) & ln);
    end
    if (ev && ew < 5'd31) m[ew] = m[ew] | (eb & m_w1c(int'(ew)));
    req_valid = v; req_write = wr; req_addr = a; req_size = s; req_wdata = d;
    evt_valid = ev; evt_word = ew; evt_bits = eb;
    @(posedge clk);
    #1;
    chk(tag, {rsp_valid, rsp_err, rsp_rdata}, {v, v && !lg, ed});
  endtask

  task automatic rd(input logic [11:0] a, input logic [2:0] s, input string tag);
    step(1'b1, 1'b0, a, s, 32'h0, 1'b0, 5'd0, 32'h0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [2:0] s, input logic [31:0] d,
                    input string tag);
    step(1'b1, 1'b1, a, s, d, 1'b0, 5'd0, 32'h0, tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 31; i++) m[i] = 32'h0;
    m[0] = 32'h0B1EA5C3; m[1] = 32'h00100000; m[2] = 32'h06040002;
    m[3] = 32'h00010010; m[13] = 32'h40; m[16] = 32'h01420010;
    rst = 1'b1; req_valid = 0; req_write = 0; req_addr = 0; req_size = 0;
    req_wdata = 0; evt_valid = 0; evt_word = 0; evt_bits = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset outputs", {rsp_valid, rsp_err, rsp_rdata}, 34'h0);
    rst = 1'b0;
    // R8 reset contents
    rd(12'h000, 3'd4, "R8"); rd(12'h004, 3'd4, "R8"); rd(12'h008, 3'd4, "R8");
    rd(12'h00C, 3'd4, "R8"); rd(12'h034, 3'd4, "R8"); rd(12'h040, 3'd4, "R8");
    // R4 the instance without capability stops at 0x40
    chk("R4 no-cap window", {r1_valid, r1_err, r1_rdata}, {2'b10, 32'h0});
    rd(12'h034, 3'd4, "R8");
    chk("R8 no-cap pointer", {r1_valid, r1_err, r1_rdata}, {2'b10, 32'h0});
    // R2 narrow reads
    rd(12'h002, 3'd2, "R2"); rd(12'h003, 3'd1, "R2"); rd(12'h042, 3'd2, "R2");
    rd(12'h003, 3'd2, "R2"); rd(12'h00A, 3'd4, "R2");
    // R9 command/status, R13 back-to-back visibility
    wr(12'h004, 3'd4, 32'hFFFFFFFF, "R9"); rd(12'h004, 3'd4, "R13");
    step(1'b0, 1'b0, 12'h0, 3'd0, 32'h0, 1'b1, 5'd1, 32'hFFFFFFFF, "R12");
    rd(12'h004, 3'd4, "R12");
    wr(12'h007, 3'd1, 32'h08, "R7"); rd(12'h006, 3'd2, "R7");
    wr(12'h004, 3'd2, 32'hFFFF, "R7"); rd(12'h004, 3'd4, "R7");
    // R12 set wins over same-cycle clear
    step(1'b1, 1'b1, 12'h004, 3'd4, 32'hFFFF0000, 1'b1, 5'd1, 32'h80000000, "R12");
    rd(12'h004, 3'd4, "R12");
    // R10 base/limit masks
    wr(12'h020, 3'd4, 32'hFFFFFFFF, "R10"); rd(12'h020, 3'd4, "R10");
    wr(12'h024, 3'd4, 32'h12345678, "R10"); rd(12'h024, 3'd4, "R10");
    wr(12'h01C, 3'd1, 32'hFF, "R10"); wr(12'h01D, 3'd1, 32'hFF, "R10");
    rd(12'h01C, 3'd4, "R10");
    // R5 reserved bits
    wr(12'h038, 3'd4, 32'hFFFFFFFF, "R5"); rd(12'h038, 3'd4, "R5");
    wr(12'h03C, 3'd4, 32'hFFFFFFFF, "R5"); rd(12'h03C, 3'd4, "R5");
    // R3 illegal size
    wr(12'h028, 3'd3, 32'hFFFFFFFF, "R3"); rd(12'h028, 3'd4, "R3");
    rd(12'h028, 3'd0, "R3");
    // R4 window edge
    rd(12'h078, 3'd4, "R4"); wr(12'h07C, 3'd4, 32'hFFFFFFFF, "R4");
    rd(12'h07C, 3'd4, "R4"); rd(12'h07E, 3'd2, "R4");
    // R6 narrow write with 4-byte offset ignored and half at offset 3
    wr(12'h02A, 3'd4, 32'hCAFEF00D, "R6"); rd(12'h028, 3'd4, "R6");
    wr(12'h02B, 3'd2, 32'h00A5, "R6"); rd(12'h028, 3'd4, "R6");
    // R11 capability words
    wr(12'h048, 3'd4, 32'hFFFFFFFF, "R11");
    step(1'b0, 1'b0, 12'h0, 3'd0, 32'h0, 1'b1, 5'd18, 32'hFFFFFFFF, "R11");
    rd(12'h048, 3'd4, "R11"); wr(12'h04A, 3'd1, 32'h05, "R11"); rd(12'h048, 3'd4, "R11");
    wr(12'h050, 3'd4, 32'hFFFFFFFF, "R11");
    step(1'b0, 1'b0, 12'h0, 3'd0, 32'h0, 1'b1, 5'd20, 32'hFFFFFFFF, "R11");
    rd(12'h050, 3'd4, "R11"); wr(12'h053, 3'd1, 32'h40, "R11"); rd(12'h050, 3'd4, "R11");
    // R1 idle cycles, then mixed traffic
    step(1'b0, 1'b0, 12'h0, 3'd0, 32'h0, 1'b0, 5'd0, 32'h0, "R1");
    for (int k = 0; k < 1500; k++) begin
      logic [31:0] r0, r1v, r2, r3;
      r0 = $urandom; r1v = $urandom; r2 = $urandom; r3 = $urandom;
      step(r0[1:0] != 2'b00, r0[2], 12'(r1v % 136), 3'(r0[10:8] % 6), r2,
           r0[13:12] == 2'b00, r0[20:16], r3, "R6");
    end
    rd(12'h000, 3'd4, "R1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule